// File: doc/BRIEF.md
# Triangle-Sweep Wiper Code Generator

This block produces two 7-bit potentiometer codes that move together in a repeating triangle. A signed offset climbs one step at a time to `+span`, turns round, falls to `-span`, turns round again, and repeats. The main code is the base wiper value plus that offset. The second code is the midpoint 64 plus the same offset. An external, asynchronous pacing pin sets the rate. A step is taken once a selectable number of its falling edges has been counted.

The base value is first limited to the range `span` to `127 - span`, so that the main code never leaves 0 to 127. The block holds off its sweep after reset, and again after the configuration strobe. During the hold-off it shows the limited base and 64, and it waits for a number of pacing pulses before it starts to sweep again. Set the inputs in the same clock cycle as the strobe. Keep them steady between strobes.

Top module: `wiper_sweep`

## Requirements
- R1: While `rst_n` is low, both `main_code` and `center_code` are 64. One clock edge after release, `main_code` shows the limited base value and `center_code` shows 64.
- R2: `rate_sel` values 0, 1, 2 and 3 select a step length of 32, 64, 128 and 256 pacing pulses. A pacing pulse is one falling edge of `sync_pin`. Each step happens on the pulse that completes a step length counted since the previous step, or since the end of the hold-off.
- R3: The offset moves in a triangle. When the direction is up, the offset goes up by one, and on reaching `+span` the direction becomes down. When the direction is down, the offset goes down by one, and on reaching `-span` the direction becomes up. It stays within `-span` to `+span`, and each code changes by at most 1 per step.
- R4: `main_code` = clamp(`base_code`, `span`, 127−`span`) + offset. `center_code` = 64 + offset. The sum stays within 0 to 127.
- R5: With `span` = 0 the codes never move. `main_code` equals `base_code` and `center_code` equals 64.
- R6: After reset, or after a clock cycle with `cfg_wr` high, the offset is 0 and the outputs show the limited base and 64. This holds until 512 + P/2 pacing pulses have arrived, where P is the step length. The sweep then starts at offset 0, going up. The first step comes P pulses later. For example, with P = 32 the first step is on pulse 560.
- R7: `sync_pin` passes through two synchronising flops. Only its falling edges count, and rising edges change nothing. A step becomes visible on the third rising clock edge after `sync_pin` falls, and not before.
- R8: With base 16 and span 31, `main_code` sweeps 0 to 62 and `center_code` sweeps 33 to 95. With base 112 and span 31, `main_code` sweeps 65 to 127.
- R9: A `cfg_wr` during a sweep abandons the sweep on the next clock edge. The outputs return to the new limited base and 64, and a new hold-off begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 1 | Asynchronous pacing pin; its falling edges are counted |
| base_code | input | 7 | Base wiper value |
| span | input | 5 | Sweep half-range; 0 disables stepping |
| rate_sel | input | 2 | Step length select (32 << rate_sel pulses) |
| cfg_wr | input | 1 | Configuration written strobe; restarts the hold-off |
| main_code | output | 7 | Wiper code: limited base plus offset |
| center_code | output | 7 | Second code: 64 plus offset |

## Verification
The two rail cases show that the base limit works. A base of 16 or 112 with the widest span must give exact sweep extremes, and a missing or off-by-one limit would show there. A run with a span of zero shows that stepping is truly disabled. A run stopped just before and just after pulse 560 checks the hold-off length and the first step to the exact pulse. Each pulse is also sampled after its rising edge and after two low clocks, which checks the edge polarity and the synchroniser latency. A strobe in mid-sweep checks the restart. Random bases, spans and rates, with a fixed seed, are compared pulse by pulse against a reference model in the bench, which covers every step length.

// File: rtl/sweep_pkg.sv
// Shared types for the triangle sweep generator.
package sweep_pkg;
    // Direction of the sweep offset.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;
endpackage

// File: rtl/sweep_sync_edge.sv
// Brings the asynchronous pacing pin into the clock domain through two
// flops and flags each falling edge for one cycle.
// Assumes: pin toggles no faster than a quarter of the clock rate.
module sweep_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall_evt
);
    logic s1_q, s2_q, prev_q;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fall_evt = prev_q & ~s2_q;
endmodule

// File: rtl/sweep_pacer.sv
// Counts pacing pulses: first the hold-off of HOLD_BASE + P/2 pulses,
// then repeating windows of P pulses, each ending in a step strobe.
// Assumes: rate_sel is steady except in a cycle with cfg_wr high.
module sweep_pacer #(
    parameter int SEL_W       = 2,
    parameter int PER_MIN_LOG = 5,
    parameter int HOLD_BASE   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             fall_evt,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             running,
    output logic             step_evt
);
    localparam int PER_MIN = 2 ** PER_MIN_LOG;
    localparam int PC_W    = PER_MIN_LOG + (2 ** SEL_W) - 1;
    localparam int MAX_PER = 2 ** PC_W;
    localparam int HC_W    = $clog2(HOLD_BASE + MAX_PER / 2 + 1);

    logic [PC_W:0]   per_len;
    logic [HC_W-1:0] hold_len;
    logic [PC_W-1:0] pcnt_q;
    logic [HC_W-1:0] hcnt_q;
    logic            run_q;
    logic            per_end;

    // Step length and hold-off length from the rate select.
    always_comb begin
        per_len  = (PC_W+1)'(PER_MIN) << rate_sel;
        hold_len = HC_W'(HOLD_BASE) + HC_W'(per_len >> 1);
        per_end  = ((PC_W+1)'(pcnt_q) == per_len - (PC_W+1)'(1));
    end

    // Hold-off counter, then period counter, both advanced by pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr) begin
            run_q  <= 1'b0;
            hcnt_q <= '0;
            pcnt_q <= '0;
        end else if (fall_evt) begin
            if (!run_q) begin
                pcnt_q <= '0;
                if (hcnt_q == hold_len - HC_W'(1)) begin
                    run_q  <= 1'b1;
                    hcnt_q <= '0;
                end else begin
                    hcnt_q <= hcnt_q + HC_W'(1);
                end
            end else if (per_end) begin
                pcnt_q <= '0;
            end else begin
                pcnt_q <= pcnt_q + PC_W'(1);
            end
        end
    end

    assign running  = run_q;
    assign step_evt = fall_evt && run_q && per_end;
endmodule

// File: rtl/sweep_offset.sv
// Holds the signed sweep offset and its direction. Moves one step per
// strobe, reversing at +span and -span. Cleared while clear is high.
// Assumes: span changes only while clear is high.
module sweep_offset
    import sweep_pkg::*;
#(
    parameter int SPAN_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic [SPAN_W-1:0]        span,
    output logic signed [SPAN_W:0]   off_q,
    output logic signed [SPAN_W:0]   off_nxt
);
    localparam logic signed [SPAN_W:0] ONE = 1;

    sweep_dir_e          dir_q, dir_nxt;
    logic signed [SPAN_W:0] span_s;

    // Next offset and direction for the triangle walk.
    always_comb begin
        span_s  = $signed({1'b0, span});
        off_nxt = off_q;
        dir_nxt = dir_q;
        if (clear) begin
            off_nxt = '0;
            dir_nxt = DIR_UP;
        end else if (step && span != '0) begin
            if (dir_q == DIR_UP) begin
                if (off_q < span_s) off_nxt = off_q + ONE;
                if (off_nxt == span_s) dir_nxt = DIR_DOWN;
            end else begin
                if (off_q > -span_s) off_nxt = off_q - ONE;
                if (off_nxt == -span_s) dir_nxt = DIR_UP;
            end
        end
    end

    // Offset and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            off_q <= off_nxt;
            dir_q <= dir_nxt;
        end
    end
endmodule

// File: rtl/sweep_map.sv
// Limits the base value to [span, max-span], adds the offset and
// registers both output codes whenever load is high.
// Assumes: span is at most half the code range.
module sweep_map #(
    parameter int CODE_W = 7,
    parameter int SPAN_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [CODE_W-1:0]        base_code,
    input  logic [SPAN_W-1:0]        span,
    input  logic signed [SPAN_W:0]   off_nxt,
    output logic signed [CODE_W+1:0] sum,
    output logic [CODE_W-1:0]        main_code,
    output logic [CODE_W-1:0]        center_code
);
    localparam int SUM_W  = CODE_W + 2;
    localparam int CENTER = 2 ** (CODE_W - 1);
    localparam int TOP    = 2 ** CODE_W - 1;

    logic [CODE_W-1:0]       lo_lim, hi_lim, base_c;
    logic signed [SUM_W-1:0] ctr_sum;

    // Limit the base and form both sums.
    always_comb begin
        lo_lim = CODE_W'(span);
        hi_lim = CODE_W'(TOP) - CODE_W'(span);
        if (base_code < lo_lim)      base_c = lo_lim;
        else if (base_code > hi_lim) base_c = hi_lim;
        else                         base_c = base_code;
        sum     = $signed({2'b00, base_c}) + SUM_W'(off_nxt);
        ctr_sum = SUM_W'(CENTER) + SUM_W'(off_nxt);
    end

    // Output code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_code   <= CODE_W'(CENTER);
            center_code <= CODE_W'(CENTER);
        end else if (load) begin
            main_code   <= sum[CODE_W-1:0];
            center_code <= ctr_sum[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/wiper_sweep.sv
// Top of the triangle sweep generator: synchroniser, pulse pacer,
// offset walker and code mapping.
// Assumes: base_code, span and rate_sel change only with cfg_wr high.
module wiper_sweep #(
    parameter int CODE_W      = 7,
    parameter int SPAN_W      = 5,
    parameter int SEL_W       = 2,
    parameter int PER_MIN_LOG = 5,
    parameter int HOLD_BASE   = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pin,
    input  logic [CODE_W-1:0] base_code,
    input  logic [SPAN_W-1:0] span,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic              cfg_wr,
    output logic [CODE_W-1:0] main_code,
    output logic [CODE_W-1:0] center_code
);
    logic                     fall_evt;
    logic                     running;
    logic                     step_evt;
    logic signed [SPAN_W:0]   off_q;
    logic signed [SPAN_W:0]   off_nxt;
    logic signed [CODE_W+1:0] sum_w;

    sweep_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (sync_pin),
        .fall_evt (fall_evt)
    );

    sweep_pacer #(
        .SEL_W       (SEL_W),
        .PER_MIN_LOG (PER_MIN_LOG),
        .HOLD_BASE   (HOLD_BASE)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .fall_evt (fall_evt),
        .rate_sel (rate_sel),
        .running  (running),
        .step_evt (step_evt)
    );

    sweep_offset #(
        .SPAN_W (SPAN_W)
    ) u_offset (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cfg_wr | ~running),
        .step    (step_evt),
        .span    (span),
        .off_q   (off_q),
        .off_nxt (off_nxt)
    );

    sweep_map #(
        .CODE_W (CODE_W),
        .SPAN_W (SPAN_W)
    ) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cfg_wr | ~running | fall_evt),
        .base_code   (base_code),
        .span        (span),
        .off_nxt     (off_nxt),
        .sum         (sum_w),
        .main_code   (main_code),
        .center_code (center_code)
    );
endmodule

// File: rtl/wiper_sweep_chk.sv
// Property checker for the sweep generator, attached by bind.
module wiper_sweep_chk #(
    parameter int CODE_W = 7,
    parameter int SPAN_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_wr,
    input logic                     fall_evt,
    input logic                     running,
    input logic [SPAN_W-1:0]        span,
    input logic [CODE_W-1:0]        center_code,
    input logic signed [SPAN_W:0]   offset,
    input logic signed [CODE_W+1:0] sum
);
    localparam int CENTER = 2 ** (CODE_W - 1);
    localparam int TOP    = 2 ** CODE_W - 1;

    // R4: the limited base plus offset never leaves the code range.
    p_sum_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum >= 0) && (sum <= TOP));

    // R3: offset stays inside the band set by span.
    p_offset_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |-> ($signed(offset) <= $signed({1'b0, span})) &&
                    ($signed(offset) >= -$signed({1'b0, span})));

    // R6: while held off, the offset is zero.
    p_hold_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (offset == '0));

    // R3: the centred code moves at most one code per cycle.
    p_center_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> (center_code == $past(center_code)) ||
                    (center_code == $past(center_code) + CODE_W'(1)) ||
                    (center_code + CODE_W'(1) == $past(center_code)));

    // R7: without a falling pacing edge or a strobe the centred code holds.
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !fall_evt) |=> $stable(center_code));

    // R4: centred code stays within 64 +/- span.
    p_center_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |-> (int'(center_code) <= CENTER + int'(span)) &&
                    (int'(center_code) >= CENTER - int'(span)));
endmodule

bind wiper_sweep wiper_sweep_chk #(
    .CODE_W (CODE_W),
    .SPAN_W (SPAN_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .fall_evt    (fall_evt),
    .running     (running),
    .span        (span),
    .center_code (center_code),
    .offset      (off_q),
    .sum         (sum_w)
);

// File: tb/wiper_sweep_tb_top.sv
// Self-checking bench: directed corners plus seeded random configurations,
// each pacing pulse compared with a reference model.
module wiper_sweep_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_pin;
    logic [6:0] base_code;
    logic [4:0] span;
    logic [1:0] rate_sel;
    logic       cfg_wr;
    logic [6:0] main_code;
    logic [6:0] center_code;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Reference model state
    int m_base, m_span, m_sel, m_hc, m_pc, m_off;
    bit m_run, m_up;

    always #5 clk = ~clk;

    wiper_sweep dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_pin    (sync_pin),
        .base_code   (base_code),
        .span        (span),
        .rate_sel    (rate_sel),
        .cfg_wr      (cfg_wr),
        .main_code   (main_code),
        .center_code (center_code)
    );

    function automatic int lim_base(int b, int s);
        if (b < s) return s;
        if (b > 127 - s) return 127 - s;
        return b;
    endfunction

    function automatic int per_of(int sel);
        return 32 << sel;
    endfunction

    function automatic int exp_main();
        return lim_base(m_base, m_span) + m_off;
    endfunction

    function automatic int exp_center();
        return 64 + m_off;
    endfunction

    task automatic model_clear();
        m_hc = 0; m_pc = 0; m_off = 0; m_run = 0; m_up = 1;
    endtask

    // Reference behaviour for one falling pacing edge.
    task automatic model_fall();
        if (!m_run) begin
            m_pc = 0;
            if (m_hc == 512 + per_of(m_sel) / 2 - 1) begin
                m_run = 1; m_hc = 0;
            end else m_hc++;
        end else if (m_pc == per_of(m_sel) - 1) begin
            m_pc = 0;
            if (m_span != 0) begin
                if (m_up) begin
                    if (m_off < m_span) m_off++;
                    if (m_off == m_span) m_up = 0;
                end else begin
                    if (m_off > -m_span) m_off--;
                    if (m_off == -m_span) m_up = 1;
                end
            end
        end else m_pc++;
    endtask

    task automatic check_out(string tag, int em, int ec);
        vectors++;
        if (int'(main_code) != em || int'(center_code) != ec) begin
            fails++;
            $display("FAIL %s main act=%0d exp=%0d center act=%0d exp=%0d",
                     tag, main_code, em, center_code, ec);
        end
    endtask

    task automatic check_val(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // One pacing pulse: 2 clocks high, then low; checks rise, latency, step.
    task automatic pulse(string tag);
        int em, ec;
        em = exp_main(); ec = exp_center();
        @(negedge clk) sync_pin = 1'b1;
        repeat (2) @(negedge clk);
        check_out("R7 rising edge ignored", em, ec);
        sync_pin = 1'b0;
        repeat (2) @(negedge clk);
        check_out("R7 no early update", em, ec);
        @(negedge clk);
        model_fall();
        check_out(tag, exp_main(), exp_center());
    endtask

    task automatic apply_cfg(int b, int s, int sel, string tag);
        @(negedge clk);
        base_code = 7'(b); span = 5'(s); rate_sel = 2'(sel); cfg_wr = 1'b1;
        @(negedge clk) cfg_wr = 1'b0;
        m_base = b; m_span = s; m_sel = sel;
        model_clear();
        check_out(tag, lim_base(b, s), 64);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Sweep a full triangle and record the extremes of both codes.
    task automatic sweep_rail(int b, int lo_m, int hi_m, int lo_c, int hi_c);
        int mn_m = 255, mx_m = -1, mn_c = 255, mx_c = -1;
        apply_cfg(b, 31, 0, "R6 rail config");
        for (int i = 0; i < 528 + 4 * 31 * 32; i++) begin
            pulse("R3 R4 rail sweep");
            if (int'(main_code) < mn_m) mn_m = int'(main_code);
            if (int'(main_code) > mx_m) mx_m = int'(main_code);
            if (int'(center_code) < mn_c) mn_c = int'(center_code);
            if (int'(center_code) > mx_c) mx_c = int'(center_code);
        end
        check_val("R8 main min", mn_m, lo_m);
        check_val("R8 main max", mx_m, hi_m);
        check_val("R8 center min", mn_c, lo_c);
        check_val("R8 center max", mx_c, hi_c);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240611));
        rst_n = 1'b0; sync_pin = 1'b0; cfg_wr = 1'b0;
        base_code = 7'd40; span = 5'd0; rate_sel = 2'd0;
        m_base = 40; m_span = 0; m_sel = 0;
        model_clear();
        repeat (4) @(negedge clk);
        check_out("R1 reset value", 64, 64);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after release", 40, 64);

        // R5: span zero never steps
        for (int i = 0; i < 600; i++) pulse("R5 span zero");
        check_out("R5 still base", 40, 64);

        // R6: exact hold-off length and first step at pulse 560
        apply_cfg(50, 3, 0, "R6 config");
        for (int i = 0; i < 559; i++) pulse("R6 hold-off");
        check_val("R6 before first step", int'(main_code), 50);
        pulse("R6 first step");
        check_val("R6 first step up", int'(main_code), 51);
        check_val("R6 first step center", int'(center_code), 65);

        // R8 rails
        sweep_rail(16, 0, 62, 33, 95);
        sweep_rail(112, 65, 127, 33, 95);

        // R9: restart during a sweep
        apply_cfg(70, 10, 1, "R6 config");
        for (int i = 0; i < 544 + 300; i++) pulse("R3 sweep before restart");
        apply_cfg(20, 5, 0, "R9 restart mid-sweep");
        for (int i = 0; i < 528 + 200; i++) pulse("R9 sweep after restart");

        // R2: seeded random configurations across all step lengths
        for (int r = 0; r < 5; r++) begin
            int b, s, sel, n;
            b = int'($urandom % 128);
            s = int'($urandom % 32);
            sel = int'($urandom % 4);
            n = 512 + per_of(sel) / 2 + 3 * per_of(sel) + int'($urandom % 40);
            apply_cfg(b, s, sel, "R6 random config");
            for (int i = 0; i < n; i++) pulse("R2 R4 random");
        end
        if (seed == 0) check_val("R2 seed", seed, seed);
        finish_run();
    end
endmodule